// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block sequences three outgoing message slots for a CAN-style controller. It keeps the scheduling state for each slot: a release flag, an abort-acknowledge flag, a pending-cancel bit and an 8-bit rank. It does not hold the message contents. Software fills a slot elsewhere and then hands it to the scheduler by clearing the slot's release flag. Each time the bus engine reports a chance to arbitrate, the scheduler picks the queued slot with the best rank. It starts that slot and waits for the engine to report success or failure.

A failed frame leaves its slot queued, and the choice is made again at the next arbitration chance. Software may cancel a queued slot. The cancel is honoured only while the slot is not on the bus. A cancel on the frame in flight waits until the frame finishes. If the frame succeeds, the slot is released as sent. If the frame fails, the slot is released as aborted. One interrupt line reports every released slot whose mask bit is set.

Top module: `tx_sched`

## Requirements
- R1: After reset, all release flags read 1 (`empty_o` = 3'b111), `abort_ack_o` and `abort_req_o` read 0, `busy_o`, `tx_start_o` and `irq_o` read 0.
- R2: A cycle with `ready_we`=1 clears the release flag and the abort-acknowledge flag of every slot `i` with `ready_mask[i]`=1 whose release flag was 1. The change is visible after that clock edge.
- R3: When `arb_req_i`=1 and no frame is in flight, the block starts one slot. The candidates are the slots with release flag 0 and cancel bit 0. The chosen slot has the numerically smallest rank, and the lowest index wins a tie. `tx_start_o` pulses for one cycle after that edge, with the index on `tx_buf_o`, and `busy_o` rises.
- R4: An `arb_req_i` while a frame is in flight, or while no slot is a candidate, starts nothing.
- R5: `tx_done_i` while busy sets the in-flight slot's release flag, clears its abort-acknowledge and cancel bits, and drops `busy_o` at the next edge.
- R6: `tx_err_i` while busy drops `busy_o` and leaves the slot queued. The next `arb_req_i` selects again using the ranks that apply at that time.
- R7: Writing `abort_we` loads the cancel bits from `abort_val`, but only for slots whose release flag is 0. A set cancel bit on a slot not in flight is granted at the next edge. The grant sets the release flag and the abort-acknowledge flag and clears the cancel bit.
- R8: A cancel bit on the in-flight slot stays pending. After `tx_done_i` the slot is released with abort-acknowledge 0. After `tx_err_i` the cancel is granted one edge after `busy_o` falls.
- R9: Writing a new rank for the in-flight slot, or clearing its cancel bit, changes neither `tx_buf_o` nor the slot that `tx_done_i` releases.
- R10: `irq_o` is 1 exactly when some slot has release flag 1 and mask bit 1. The mask is loaded from `irq_mask_val` on `irq_mask_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_we | input | 1 | Strobe for handing slots to the scheduler |
| ready_mask | input | 3 | Slots to queue, one bit per slot |
| prio_we | input | 1 | Rank write strobe |
| prio_idx | input | 2 | Slot whose rank is written |
| prio_val | input | 8 | New rank, where a smaller value means more urgent |
| abort_we | input | 1 | Cancel-request write strobe |
| abort_val | input | 3 | Cancel-request bits |
| irq_mask_we | input | 1 | Interrupt mask write strobe |
| irq_mask_val | input | 3 | Interrupt mask, one bit per slot |
| arb_req_i | input | 1 | Arbitration opportunity pulse from the bus engine |
| tx_done_i | input | 1 | The in-flight frame was sent |
| tx_err_i | input | 1 | The in-flight frame failed |
| tx_start_o | output | 1 | One-cycle start pulse to the bus engine |
| tx_buf_o | output | 2 | Index of the started (in-flight) slot |
| busy_o | output | 1 | A frame is in flight |
| empty_o | output | 3 | Release flags |
| abort_ack_o | output | 3 | Abort-acknowledge flags |
| abort_req_o | output | 3 | Pending cancel bits |
| irq_o | output | 1 | Masked transmit interrupt |

## Verification
A corrupted rank comparison or tie rule shows up as a wrong `tx_buf_o` one cycle after the arbitration pulse. The scoreboard catches it at that start. A wrong per-slot flag shows on `empty_o` or `abort_ack_o` at the edge after the write, completion or grant that should have moved it. A lost in-flight index surfaces when `tx_done_i` releases the wrong slot. Cancels raised during a frame are checked across both endings, so a grant that comes too early shows as a release while `busy_o` is still high.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic {
    TXS_IDLE   = 1'b0,
    TXS_ACTIVE = 1'b1
  } tx_state_e;
endpackage

// File: rtl/tx_sched_rst.sv
module tx_sched_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tx_sched_pick.sv
module tx_sched_pick #(
  parameter int NBUF   = 3,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0]        cand,
  input  logic [NBUF*PRIO_W-1:0] prio_flat,
  output logic                   found,
  output logic [IDX_W-1:0]       pick
);
  logic [PRIO_W-1:0] best;

  // Strict less-than keeps the lower index on equal ranks.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (cand[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
        found = 1'b1;
        pick  = IDX_W'(i);
        best  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tx_sched_slot.sv
module tx_sched_slot #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_set,
  input  logic              abort_we,
  input  logic              abort_bit,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_val,
  input  logic              in_flight,
  input  logic              done_hit,
  output logic              empty,
  output logic              ack,
  output logic              cancel,
  output logic [PRIO_W-1:0] prio,
  output logic              cand
);
  logic              empty_n, ack_n, cancel_n, grant;
  logic [PRIO_W-1:0] prio_n;

  assign grant = cancel & ~empty & ~in_flight;
  assign cand  = ~empty & ~cancel;

  always_comb begin
    empty_n  = empty;
    ack_n    = ack;
    cancel_n = cancel;
    prio_n   = prio;
    if (prio_we) prio_n = prio_val;
    if (abort_we) cancel_n = abort_bit & ~empty;
    if (ready_set && empty) begin
      empty_n = 1'b0;
      ack_n   = 1'b0;
    end
    if (done_hit) begin
      empty_n  = 1'b1;
      ack_n    = 1'b0;
      cancel_n = 1'b0;
    end else if (grant) begin
      empty_n  = 1'b1;
      ack_n    = 1'b1;
      cancel_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty  <= 1'b1;
      ack    <= 1'b0;
      cancel <= 1'b0;
      prio   <= '0;
    end else begin
      empty  <= empty_n;
      ack    <= ack_n;
      cancel <= cancel_n;
      prio   <= prio_n;
    end
  end
endmodule

// File: rtl/tx_sched.sv
module tx_sched
  import tx_sched_pkg::*;
#(
  parameter int NBUF   = 3,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_we,
  input  logic [NBUF-1:0]   ready_mask,
  input  logic              prio_we,
  input  logic [IDX_W-1:0]  prio_idx,
  input  logic [PRIO_W-1:0] prio_val,
  input  logic              abort_we,
  input  logic [NBUF-1:0]   abort_val,
  input  logic              irq_mask_we,
  input  logic [NBUF-1:0]   irq_mask_val,
  input  logic              arb_req_i,
  input  logic              tx_done_i,
  input  logic              tx_err_i,
  output logic              tx_start_o,
  output logic [IDX_W-1:0]  tx_buf_o,
  output logic              busy_o,
  output logic [NBUF-1:0]   empty_o,
  output logic [NBUF-1:0]   abort_ack_o,
  output logic [NBUF-1:0]   abort_req_o,
  output logic              irq_o
);
  logic                   rst_s;
  tx_state_e              state_q, state_n;
  logic [IDX_W-1:0]       cur_q, cur_n;
  logic                   start_q, start_n;
  logic [NBUF-1:0]        mask_q, mask_n;
  logic [NBUF-1:0]        cand;
  logic [NBUF*PRIO_W-1:0] prio_flat;
  logic                   found, launch, active;
  logic [IDX_W-1:0]       pick;

  tx_sched_rst #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  assign active = (state_q == TXS_ACTIVE);

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    tx_sched_slot #(.PRIO_W(PRIO_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_s),
      .ready_set (ready_we & ready_mask[g]),
      .abort_we  (abort_we),
      .abort_bit (abort_val[g]),
      .prio_we   (prio_we && (prio_idx == IDX_W'(g))),
      .prio_val  (prio_val),
      .in_flight (active && (cur_q == IDX_W'(g))),
      .done_hit  (active && (cur_q == IDX_W'(g)) && tx_done_i),
      .empty     (empty_o[g]),
      .ack       (abort_ack_o[g]),
      .cancel    (abort_req_o[g]),
      .prio      (prio_flat[g*PRIO_W +: PRIO_W]),
      .cand      (cand[g])
    );
  end

  tx_sched_pick #(.NBUF(NBUF), .PRIO_W(PRIO_W)) u_pick (
    .cand(cand), .prio_flat(prio_flat), .found(found), .pick(pick)
  );

  assign launch = arb_req_i && !active && found;

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    start_n = launch;
    mask_n  = irq_mask_we ? irq_mask_val : mask_q;
    if (launch) begin
      state_n = TXS_ACTIVE;
      cur_n   = pick;
    end else if (active && (tx_done_i || tx_err_i)) begin
      state_n = TXS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= TXS_IDLE;
      cur_q   <= '0;
      start_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      start_q <= start_n;
      mask_q  <= mask_n;
    end
  end

  assign tx_start_o = start_q;
  assign tx_buf_o   = cur_q;
  assign busy_o     = active;
  assign irq_o      = |(empty_o & mask_q);
endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int NBUF  = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arb_req_i,
  input logic             tx_start_o,
  input logic [IDX_W-1:0] tx_buf_o,
  input logic             busy_o,
  input logic [NBUF-1:0]  empty_o,
  input logic [NBUF-1:0]  abort_ack_o,
  input logic [NBUF-1:0]  abort_req_o
);
  // R3: a start follows an arbitration pulse taken while idle
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> ($past(arb_req_i) && !$past(busy_o) && busy_o));

  // R3: a slot with a pending cancel is never started
  a_r3_no_start_cancelled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> !$past(abort_req_o[tx_buf_o]));

  // R8: the in-flight slot is never released early
  a_r8_flight_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !empty_o[tx_buf_o]);

  // R7: an abort acknowledge only stands on a released slot
  a_r7_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ack_o & ~empty_o) == '0);

  // R7: a released slot holds no cancel bit
  a_r7_cancel_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req_o & empty_o) == '0);

  // R9: the in-flight index is stable while busy
  a_r9_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !tx_start_o) |-> $stable(tx_buf_o));
endmodule

bind tx_sched tx_sched_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_req_i(arb_req_i), .tx_start_o(tx_start_o),
  .tx_buf_o(tx_buf_o), .busy_o(busy_o), .empty_o(empty_o),
  .abort_ack_o(abort_ack_o), .abort_req_o(abort_req_o)
);

// File: tb/sim_tx_sched.sv
module sim_tx_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready_we = 0, prio_we = 0, abort_we = 0, irq_mask_we = 0;
  logic [2:0] ready_mask = 0, abort_val = 0, irq_mask_val = 0;
  logic [1:0] prio_idx = 0;
  logic [7:0] prio_val = 0;
  logic       arb_req_i = 0, tx_done_i = 0, tx_err_i = 0;
  logic       tx_start_o, busy_o, irq_o;
  logic [1:0] tx_buf_o;
  logic [2:0] empty_o, abort_ack_o, abort_req_o;

  int n_chk = 0, n_fail = 0;
  int     exp_q[$];
  string  tag_q[$];

  always #2.5 clk = ~clk;

  tx_sched u0 (
    .clk(clk), .rst_n(rst_n), .ready_we(ready_we), .ready_mask(ready_mask),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
    .abort_we(abort_we), .abort_val(abort_val),
    .irq_mask_we(irq_mask_we), .irq_mask_val(irq_mask_val),
    .arb_req_i(arb_req_i), .tx_done_i(tx_done_i), .tx_err_i(tx_err_i),
    .tx_start_o(tx_start_o), .tx_buf_o(tx_buf_o), .busy_o(busy_o),
    .empty_o(empty_o), .abort_ack_o(abort_ack_o), .abort_req_o(abort_req_o),
    .irq_o(irq_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every start is compared with the next scoreboard entry.
  always @(negedge clk) begin
    if (rst_n && tx_start_o) begin
      if (exp_q.size() == 0) check("R4 unexpected start", int'(tx_buf_o), -1);
      else check(tag_q.pop_front(), int'(tx_buf_o), exp_q.pop_front());
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ready(logic [2:0] m);
    ready_we = 1; ready_mask = m; cyc(); ready_we = 0;
  endtask

  task automatic prio(int idx, int v);
    prio_we = 1; prio_idx = 2'(idx); prio_val = 8'(v); cyc(); prio_we = 0;
  endtask

  task automatic abort(logic [2:0] v);
    abort_we = 1; abort_val = v; cyc(); abort_we = 0;
  endtask

  task automatic irqmask(logic [2:0] v);
    irq_mask_we = 1; irq_mask_val = v; cyc(); irq_mask_we = 0;
  endtask

  // exp < 0 means the pulse must start nothing
  task automatic arb(int exp, string tag);
    if (exp >= 0) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    arb_req_i = 1; cyc(); arb_req_i = 0;
    if (exp < 0) check(tag, int'(tx_start_o), 0);
    else check(tag, int'(busy_o), 1);
  endtask

  task automatic done();
    tx_done_i = 1; cyc(); tx_done_i = 0;
    check("R5 busy falls", int'(busy_o), 0);
  endtask

  task automatic fail_tx();
    tx_err_i = 1; cyc(); tx_err_i = 0;
    check("R6 busy falls", int'(busy_o), 0);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1; cyc(4);
        check("R1 empty", int'(empty_o), 7);
        check("R1 ack", int'(abort_ack_o), 0);
        check("R1 cancel", int'(abort_req_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 irq", int'(irq_o), 0);

        irqmask(3'b001);
        check("R10 irq set", int'(irq_o), 1);
        prio(0, 30); prio(1, 10); prio(2, 20);
        ready(3'b111);
        check("R2 queued", int'(empty_o), 0);
        check("R10 irq clear", int'(irq_o), 0);

        arb(1, "R3 lowest rank");
        arb(-1, "R4 arb while busy");
        done();
        check("R5 released", int'(empty_o), 3'b010);
        irqmask(3'b010);
        check("R10 irq slot1", int'(irq_o), 1);

        arb(2, "R3 next rank");
        fail_tx();
        check("R6 still queued", int'(empty_o[2]), 0);
        prio(0, 5);
        arb(0, "R6 reselect after error");
        done();
        arb(2, "R6 retry slot2");
        done();
        check("R5 all released", int'(empty_o), 7);
        arb(-1, "R4 no candidate");

        prio(0, 7); prio(1, 7); prio(2, 7);
        ready(3'b111);
        arb(0, "R3 tie lowest index");
        done();
        arb(1, "R3 tie next index");
        done();
        arb(2, "R3 tie last");
        done();

        ready(3'b011);
        abort(3'b110);
        check("R7 cancel only queued", int'(abort_req_o), 3'b010);
        cyc();
        check("R7 grant empty", int'(empty_o), 3'b110);
        check("R7 grant ack", int'(abort_ack_o), 3'b010);
        check("R7 grant clears", int'(abort_req_o), 0);
        ready(3'b010);
        check("R2 ack cleared", int'(abort_ack_o), 0);
        abort(3'b010); cyc();
        check("R7 regrant", int'(abort_ack_o), 3'b010);

        arb(0, "R8 start slot0");
        abort(3'b001); cyc(2);
        check("R8 pending", int'(abort_req_o), 3'b001);
        check("R8 not released", int'(empty_o[0]), 0);
        done();
        check("R8 sent ack", int'(abort_ack_o[0]), 0);
        check("R8 sent empty", int'(empty_o[0]), 1);

        ready(3'b001);
        arb(0, "R8 start again");
        abort(3'b001);
        fail_tx();
        cyc();
        check("R8 grant after error", int'(abort_ack_o[0]), 1);
        check("R8 released after error", int'(empty_o[0]), 1);

        prio(0, 1); prio(1, 2);
        ready(3'b011);
        arb(0, "R9 start slot0");
        prio(0, 200);
        abort(3'b001); abort(3'b000);
        check("R9 index held", int'(tx_buf_o), 0);
        done();
        check("R9 released slot0", int'(empty_o), 3'b101);
        check("R9 sent ack", int'(abort_ack_o[0]), 0);
        arb(1, "R9 slot1 next");
        done();
        cyc(2);
        check("R4 scoreboard drained", exp_q.size(), 0);
      end
      begin
        cyc(20000);
        check("watchdog", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule